// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block gathers three classes of interrupt request (critical, main and peripheral) and ranks the pending, enabled sources in each class. It presents the winner of each class as a small code in one read-only status word. A processor reads this word to pick its handler. Two mask registers decide which sources may take part, and a 1 in a mask bit disables its source. A priority register marks chosen peripheral sources as urgent.

Peripheral requests are not routed to a CPU line of their own. Instead they pass through the other two classes. An urgent peripheral shows up as critical code 2, and a non-urgent one shows up as main code 4. In both cases software then reads the peripheral field to find the real source. Peripheral source 0 is the summary line of a cascaded DMA group.

The block is driven through a 32-bit register port with a 2-bit select: 0 is the peripheral mask, 1 is the main mask, 2 is the urgency register and 3 is the status word. Writes take effect at the clock edge that samples them. Reads are combinational.

Top module: `intc_top`

## Requirements
- R1: After reset the peripheral mask reads 0x7FFFFC00, the main mask reads 0x00010FFF, the urgency register reads 0 and the status word reads 0.
- R2: Peripheral source p (periphSrc[p]) is disabled while bit 31-p of the peripheral mask is 1. A disabled source has no effect on any status field.
- R3: Main source m is disabled while bit 16-m of the main mask is 1. Main sources 0..3 come from mainExt[m], and main sources 5..16 come from mainExt[m-1].
- R4: Status bit 10 is set when any critical code is pending, and bits [9:8] hold the lowest pending critical code. critExt[0], critExt[1] and critExt[2] raise codes 0, 1 and 3 respectively.
- R5: Status bit 21 is set when any enabled main source is pending, and bits [20:16] hold the lowest such main number.
- R6: Status bit 29 is set when any enabled peripheral is pending. Bits [28:24] hold the lowest enabled pending peripheral number, and code 0 denotes the DMA group summary on periphSrc[0].
- R7: When bit p of the urgency register is 1 and peripheral p is enabled and pending, critical code 2 is raised. The peripheral field then shows the lowest such urgent source, in preference to any non-urgent one.
- R8: An enabled, pending, non-urgent peripheral raises main code 4. This cascade is disabled by bit 12 of the main mask.
- R9: Every code field reads 0 while its valid bit is clear, and every status bit outside the six fields reads 0.
- R10: Writes to select 3 do not change the status word. Main mask bits 31..17 read as 0. The masks and the urgency register read back what was written.
- R11: The status word reflects the sources and register values one clock edge after they are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regSel | input | 2 | Register select: 0 peripheral mask, 1 main mask, 2 urgency, 3 status |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of the selected register |
| periphSrc | input | 32 | Peripheral request lines; bit 0 is the DMA group summary |
| mainExt | input | 16 | Main-class request lines (main number 4 omitted) |
| critExt | input | 3 | Critical request lines for codes 0, 1 and 3 |

## Verification
A mask write and a change of a source line can arrive in the same cycle. In that case the registered status must first reflect the new source judged by the old mask, and only one edge later the new mask. The bench provokes this by raising a masked peripheral in the very cycle that unmasks it. It then checks that the status stays 0 for one read and then shows that peripheral and its main-class cascade. A second overlap also gets its own checks: an urgent peripheral and an external critical line can compete for the critical field in the same cycle, and the lower code must win.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PERIPH_N = 32;
  localparam int MAIN_N   = 17;
  localparam int CRIT_N   = 4;
  localparam int CODE_W   = 5;
  localparam int MAIN_CASCADE = 4;
  localparam int CRIT_CASCADE = 2;
  localparam logic [PERIPH_N-1:0] PMASK_RST = 32'h7FFF_FC00;
  localparam logic [MAIN_N-1:0]   MMASK_RST = 17'h1_0FFF;

  typedef enum logic [1:0] {
    SEL_PMASK  = 2'd0,
    SEL_MMASK  = 2'd1,
    SEL_PRI    = 2'd2,
    SEL_STATUS = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrPMask;
    logic    wrMMask;
    logic    wrPri;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_lowest_enc.sv
module intc_lowest_enc #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set index wins; idx is 0 when nothing is requested
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl import intc_pkg::*; (
  input  logic [1:0]  regSel,
  input  logic        wrEn,
  output ctrlStrobe_t strobe
);
  regSel_e sel;
  assign sel = regSel_e'(regSel);

  always_comb begin
    strobe.wrPMask = wrEn && (sel == SEL_PMASK);
    strobe.wrMMask = wrEn && (sel == SEL_MMASK);
    strobe.wrPri   = wrEn && (sel == SEL_PRI);
    strobe.rdSel   = sel;
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath import intc_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  logic [31:0]         wrData,
  input  logic [PERIPH_N-1:0] periphSrc,
  input  logic [MAIN_N-2:0]   mainExt,
  input  logic [CRIT_N-2:0]   critExt,
  output logic [31:0]         rdData,
  output logic [31:0]         statusWord
);
  localparam int PIW = $clog2(PERIPH_N);
  localparam int MIW = $clog2(MAIN_N);
  localparam int CIW = $clog2(CRIT_N);

  logic [PERIPH_N-1:0] pMask, urgent, pEnable, pReq, hiReq, loReq;
  logic [MAIN_N-1:0]   mMask, mainReq;
  logic [CRIT_N-1:0]   critReq;
  logic                hiAny, loAny, mainAny, critAny;
  logic [PIW-1:0]      hiIdx, loIdx, pCode;
  logic [MIW-1:0]      mainIdx;
  logic [CIW-1:0]      critIdx;
  logic [31:0]         statusNext, statusQ;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pMask  <= PMASK_RST;
      mMask  <= MMASK_RST;
      urgent <= '0;
    end else begin
      if (strobe.wrPMask) pMask  <= wrData[PERIPH_N-1:0];
      if (strobe.wrMMask) mMask  <= wrData[MAIN_N-1:0];
      if (strobe.wrPri)   urgent <= wrData[PERIPH_N-1:0];
    end
  end

  // peripheral mask is bit-reversed against the source number
  for (genvar p = 0; p < PERIPH_N; p++) begin : g_pen
    assign pEnable[p] = ~pMask[PERIPH_N-1-p];
  end
  assign pReq  = periphSrc & pEnable;
  assign hiReq = pReq & urgent;
  assign loReq = pReq & ~urgent;

  intc_lowest_enc #(.W(PERIPH_N), .IW(PIW)) u_hiEnc (.req(hiReq), .any(hiAny), .idx(hiIdx));
  intc_lowest_enc #(.W(PERIPH_N), .IW(PIW)) u_loEnc (.req(loReq), .any(loAny), .idx(loIdx));
  assign pCode = hiAny ? hiIdx : loIdx;

  // main class: one slot is the non-urgent peripheral cascade
  for (genvar m = 0; m < MAIN_N; m++) begin : g_main
    if (m == MAIN_CASCADE) begin : g_casc
      assign mainReq[m] = loAny & ~mMask[MAIN_N-1-m];
    end else if (m < MAIN_CASCADE) begin : g_lo
      assign mainReq[m] = mainExt[m] & ~mMask[MAIN_N-1-m];
    end else begin : g_hi
      assign mainReq[m] = mainExt[m-1] & ~mMask[MAIN_N-1-m];
    end
  end
  intc_lowest_enc #(.W(MAIN_N), .IW(MIW)) u_mainEnc (.req(mainReq), .any(mainAny), .idx(mainIdx));

  // critical class: one slot is the urgent peripheral cascade
  for (genvar c = 0; c < CRIT_N; c++) begin : g_crit
    if (c == CRIT_CASCADE) begin : g_casc
      assign critReq[c] = hiAny;
    end else if (c < CRIT_CASCADE) begin : g_lo
      assign critReq[c] = critExt[c];
    end else begin : g_hi
      assign critReq[c] = critExt[c-1];
    end
  end
  intc_lowest_enc #(.W(CRIT_N), .IW(CIW)) u_critEnc (.req(critReq), .any(critAny), .idx(critIdx));

  always_comb begin
    statusNext        = '0;
    statusNext[29]    = hiAny | loAny;
    statusNext[28:24] = CODE_W'(pCode);
    statusNext[21]    = mainAny;
    statusNext[20:16] = CODE_W'(mainIdx);
    statusNext[10]    = critAny;
    statusNext[9:8]   = critIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= statusNext;
  end
  assign statusWord = statusQ;

  always_comb begin
    case (strobe.rdSel)
      SEL_PMASK: rdData = 32'(pMask);
      SEL_MMASK: rdData = 32'(mMask);
      SEL_PRI:   rdData = 32'(urgent);
      default:   rdData = statusQ;
    endcase
  end
endmodule

// File: rtl/intc_top.sv
module intc_top import intc_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          regSel,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [PERIPH_N-1:0] periphSrc,
  input  logic [MAIN_N-2:0]   mainExt,
  input  logic [CRIT_N-2:0]   critExt
);
  ctrlStrobe_t strobe;
  logic [31:0] statusWord;

  intc_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .strobe (strobe)
  );

  intc_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wrData     (wrData),
    .periphSrc  (periphSrc),
    .mainExt    (mainExt),
    .critExt    (critExt),
    .rdData     (rdData),
    .statusWord (statusWord)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] periphSrc,
  input logic [15:0] mainExt,
  input logic [2:0]  critExt,
  input logic [31:0] statusWord
);
  assert_crit_cascade_R7: assert property (@(posedge clk) disable iff (rst)
    (statusWord[10] && statusWord[9:8] == 2'd2) |-> statusWord[29]);

  assert_main_cascade_R8: assert property (@(posedge clk) disable iff (rst)
    (statusWord[21] && statusWord[20:16] == 5'd4) |-> statusWord[29]);

  assert_idle_fields_R9: assert property (@(posedge clk) disable iff (rst)
    (statusWord[29] || statusWord[28:24] == 5'd0) &&
    (statusWord[21] || statusWord[20:16] == 5'd0) &&
    (statusWord[10] || statusWord[9:8] == 2'd0));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (statusWord & 32'hC0C0_F8FF) == 32'h0);

  assert_quiet_inputs_R11: assert property (@(posedge clk) disable iff (rst)
    (periphSrc == '0 && mainExt == '0 && critExt == '0) |=> statusWord == 32'h0);

  assert_crit_needs_source_R4: assert property (@(posedge clk) disable iff (rst)
    (periphSrc == '0 && critExt == '0) |=> !statusWord[10]);
endmodule

bind intc_top intc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .periphSrc  (periphSrc),
  .mainExt    (mainExt),
  .critExt    (critExt),
  .statusWord (statusWord)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  regSel = 2'd0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] periphSrc = '0;
  logic [15:0] mainExt = '0;
  logic [2:0]  critExt = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_top dut (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .periphSrc(periphSrc), .mainExt(mainExt), .critExt(critExt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setSrc(input logic [31:0] p, input logic [15:0] m, input logic [2:0] c);
    @(negedge clk);
    periphSrc = p; mainExt = m; critExt = c;
  endtask

  task automatic expectStatus(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk);
    @(negedge clk);
    readReg(2'd3, v);
    chk(tag, v, exp);
  endtask

  task automatic expectReg(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    logic [31:0] v;
    readReg(sel, v);
    chk(tag, v, exp);
  endtask

  task automatic testReset();
    expectReg("R1 pmask", 2'd0, 32'h7FFF_FC00);
    expectReg("R1 mmask", 2'd1, 32'h0001_0FFF);
    expectReg("R1 urgency", 2'd2, 32'h0);
    expectReg("R1 status", 2'd3, 32'h0);
  endtask

  task automatic testLatency();
    logic [31:0] v;
    setSrc(32'h1 << 25, '0, '0);
    readReg(2'd3, v);
    chk("R11 before edge", v, 32'h0);
    @(negedge clk);
    readReg(2'd3, v);
    chk("R11 R6 one edge later", v, 32'h3924_0000);
    setSrc('0, '0, '0);
  endtask

  task automatic testPeriphMask();
    setSrc(32'h1 << 5, '0, '0);
    expectStatus("R2 masked p5", 32'h0);
    writeReg(2'd0, 32'h7BFF_FC00);
    expectStatus("R2 unmasked p5", 32'h2524_0000);
    setSrc((32'h1 << 5) | (32'h1 << 25), '0, '0);
    expectStatus("R6 lowest p5", 32'h2524_0000);
    setSrc(32'h1, '0, '0);
    expectStatus("R6 DMA code 0", 32'h2024_0000);
    setSrc('0, '0, '0);
  endtask

  task automatic testMain();
    setSrc('0, 16'h0002, '0);
    expectStatus("R5 main 1", 32'h0021_0000);
    setSrc('0, 16'h0001, '0);
    expectStatus("R3 main 0 masked", 32'h0);
    setSrc('0, 16'h0006, '0);
    expectStatus("R5 lowest main", 32'h0021_0000);
    writeReg(2'd1, 32'h0001_07FF);
    expectReg("R10 mmask readback", 2'd1, 32'h0001_07FF);
    setSrc('0, 16'h0010, '0);
    expectStatus("R3 main 5 from mainExt4", 32'h0025_0000);
    setSrc('0, '0, '0);
  endtask

  task automatic testUrgent();
    writeReg(2'd2, 32'h0200_0000);
    expectReg("R10 urgency readback", 2'd2, 32'h0200_0000);
    setSrc((32'h1 << 22) | (32'h1 << 25), '0, '0);
    expectStatus("R7 urgent p25 over p22", 32'h3924_0600);
    setSrc('0, '0, '0);
  endtask

  task automatic testCrit();
    setSrc('0, '0, 3'b001);
    expectStatus("R4 crit code 0", 32'h0000_0400);
    setSrc('0, '0, 3'b100);
    expectStatus("R4 crit code 3", 32'h0000_0700);
    setSrc(32'h1 << 25, '0, 3'b100);
    expectStatus("R4 R7 code 2 beats 3", 32'h3900_0600);
    setSrc('0, '0, '0);
  endtask

  task automatic testSameCycle();
    logic [31:0] v;
    expectStatus("R11 idle before overlap", 32'h0);
    @(negedge clk);
    periphSrc = 32'h1 << 7;
    regSel = 2'd0; wrData = 32'h7AFF_FC00; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    readReg(2'd3, v);
    chk("R11 R2 old mask in overlap", v, 32'h0);
    @(negedge clk);
    readReg(2'd3, v);
    chk("R11 R2 new mask after overlap", v, 32'h2724_0000);
    setSrc('0, '0, '0);
  endtask

  task automatic testCascadeMask();
    writeReg(2'd1, 32'h0001_17FF);
    setSrc(32'h1 << 22, '0, '0);
    expectStatus("R8 cascade masked", 32'h3600_0000);
    setSrc('0, '0, '0);
  endtask

  task automatic testIgnoredWrites();
    writeReg(2'd3, 32'hFFFF_FFFF);
    expectStatus("R10 status write ignored", 32'h0);
    expectReg("R10 pmask unchanged", 2'd0, 32'h7AFF_FC00);
    writeReg(2'd1, 32'hFFFF_FFFF);
    expectReg("R10 mmask upper zero", 2'd1, 32'h0001_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    testReset();
    testLatency();
    testPeriphMask();
    testMain();
    testUrgent();
    testCrit();
    testSameCycle();
    testCascadeMask();
    testIgnoredWrites();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule